// File: doc/BRIEF.md
# Debounced Edge Interrupt Bank

This block watches a bank of already-synchronized pad levels and turns selected transitions into latched interrupt requests. Each pin carries a small configuration field that picks which transitions count (none, rising, falling or both) and whether the pin passes through a debounce filter first. When the filter is on, a level change is only accepted once the raw pad has held the new level for a power-of-two number of millisecond ticks. The tick comes from a shared strobe input.

Accepted edges set bits in a pending-status register. Software clears a bit by writing a one to it. A mask register blocks pins from the single bank interrupt output. The mask is changed through two write-one operations: one sets mask bits and the other clears them. Bus address decoding sits outside the block. A write arrives here as an enable, a 2-bit target select and a data word.

Top module: `gpioEdgeIrq`

## Requirements
- R1: After reset every status bit is 0, every mask bit is 1 and `bankIrq` is 0.
- R2: A pin whose edge select (configuration bits [1:0]) is 01 latches its status bit when its filtered level goes from 0 to 1.
- R3: Edge select 10 latches the status bit when the filtered level goes from 1 to 0.
- R4: Edge select 11 latches on both transitions, and edge select 00 latches on neither.
- R5: A write with `wrSel` = 0 clears every status bit whose data bit is 1 and leaves bits written with 0 unchanged.
- R6: If an accepted edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R7: A write with `wrSel` = 1 sets the mask bits where the data is 1. A write with `wrSel` = 2 clears the mask bits where the data is 1. Data bits of 0 leave the mask unchanged.
- R8: Status bits latch for masked pins too. `bankIrq` is 1 exactly when some status bit is set whose mask bit is 0.
- R9: With debounce enabled (configuration bit 5), a level change is accepted on the 2^E-th `msTick` during which the raw pad has differed from the filtered level. E is configuration bits [4:2], ranging from 0 to 7. A return to the old level before that tick restarts the count and produces no edge.
- R10: With debounce disabled, a pad change latches its status bit at the first clock edge that samples the new level.
- R11: An edge that occurs after its status bit has been cleared latches the bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| padLevel | input | PINS | Synchronized pad levels |
| msTick | input | 1 | One-cycle strobe once per millisecond |
| pinCfg | input | PINS*6 | Per-pin fields; pin i at [6i+5:6i]: [1:0] edge select, [4:2] exponent, [5] debounce enable |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 status clear, 1 mask set, 2 mask clear, 3 none |
| wrData | input | PINS | Write data, one bit per pin |
| intStatus | output | PINS | Pending edge bits |
| intMask | output | PINS | Mask bits, 1 blocks the pin |
| bankIrq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `msTick` is a single-cycle pulse, and that every pad is low while reset is held, so the filtered levels start out matching the pads. The bench keeps the pads low through reset and drives ticks as isolated one-cycle pulses. Before turning debounce on, it settles a pin's filtered level by running one cycle with the filter off. Write selects are only driven together with `wrEn`.

// File: rtl/gpioIrqPkg.sv
package gpioIrqPkg;
  localparam int EDGE_W = 2;
  localparam int EXP_W  = 3;
  localparam int CFG_W  = EDGE_W + EXP_W + 1;
  localparam int CNT_W  = (1 << EXP_W) - 1;

  typedef enum logic [1:0] {
    SEL_STAT_CLR = 2'd0,
    SEL_MASK_SET = 2'd1,
    SEL_MASK_CLR = 2'd2,
    SEL_IDLE     = 2'd3
  } wrSel_e;

  typedef struct packed {
    logic statClr;
    logic maskSet;
    logic maskClr;
  } wrStrobe_t;
endpackage

// File: rtl/pinEdgeFilter.sv
module pinEdgeFilter
  import gpioIrqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             raw,
  input  logic             msTick,
  input  logic [EDGE_W-1:0] edgeSel,
  input  logic [EXP_W-1:0]  expSel,
  input  logic             dbOn,
  output logic             hit
);
  logic             lvl, nxtLvl;
  logic [CNT_W-1:0] cnt, nxtCnt;
  logic [CNT_W-1:0] lastCnt;
  logic             rise, fall;

  assign lastCnt = CNT_W'((1 << expSel) - 1);

  always_comb begin
    nxtLvl = lvl;
    nxtCnt = cnt;
    if (!dbOn) begin
      nxtLvl = raw;
      nxtCnt = '0;
    end else if (raw == lvl) begin
      nxtCnt = '0;
    end else if (msTick) begin
      if (cnt == lastCnt) begin
        nxtLvl = raw;
        nxtCnt = '0;
      end else begin
        nxtCnt = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lvl <= 1'b0;
      cnt <= '0;
    end else begin
      lvl <= nxtLvl;
      cnt <= nxtCnt;
    end
  end

  assign rise = nxtLvl & ~lvl;
  assign fall = ~nxtLvl & lvl;
  assign hit  = (edgeSel[0] & rise) | (edgeSel[1] & fall);
endmodule

// File: rtl/irqWriteCtl.sv
module irqWriteCtl
  import gpioIrqPkg::*;
(
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  output wrStrobe_t  strobe
);
  wrSel_e selDec;

  always_comb begin
    selDec = wrSel_e'(wrSel);
    strobe = '0;
    if (wrEn) begin
      unique case (selDec)
        SEL_STAT_CLR: strobe.statClr = 1'b1;
        SEL_MASK_SET: strobe.maskSet = 1'b1;
        SEL_MASK_CLR: strobe.maskClr = 1'b1;
        default:      strobe = '0;
      endcase
    end
  end
endmodule

// File: rtl/irqRegs.sv
module irqRegs
  import gpioIrqPkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  wrStrobe_t       strobe,
  input  logic [PINS-1:0] wrData,
  input  logic [PINS-1:0] hitVec,
  output logic [PINS-1:0] intStatus,
  output logic [PINS-1:0] intMask,
  output logic            bankIrq
);
  logic [PINS-1:0] clrBits, setMaskBits, clrMaskBits;

  assign clrBits     = strobe.statClr ? wrData : '0;
  assign setMaskBits = strobe.maskSet ? wrData : '0;
  assign clrMaskBits = strobe.maskClr ? wrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intStatus <= '0;
      intMask   <= '1;
    end else begin
      intStatus <= (intStatus & ~clrBits) | hitVec;
      intMask   <= (intMask | setMaskBits) & ~clrMaskBits;
    end
  end

  assign bankIrq = |(intStatus & ~intMask);
endmodule

// File: rtl/gpioEdgeIrq.sv
module gpioEdgeIrq
  import gpioIrqPkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PINS-1:0]   padLevel,
  input  logic              msTick,
  input  logic [PINS*CFG_W-1:0] pinCfg,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [PINS-1:0]   wrData,
  output logic [PINS-1:0]   intStatus,
  output logic [PINS-1:0]   intMask,
  output logic              bankIrq
);
  wrStrobe_t       strobe;
  logic [PINS-1:0] hitVec;
  logic [PINS-1:0] dbEnVec;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [CFG_W-1:0] cfg;
    assign cfg        = pinCfg[i*CFG_W +: CFG_W];
    assign dbEnVec[i] = cfg[CFG_W-1];
    pinEdgeFilter u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .raw    (padLevel[i]),
      .msTick (msTick),
      .edgeSel(cfg[EDGE_W-1:0]),
      .expSel (cfg[EDGE_W +: EXP_W]),
      .dbOn   (dbEnVec[i]),
      .hit    (hitVec[i])
    );
  end

  irqWriteCtl u_ctl (
    .wrEn  (wrEn),
    .wrSel (wrSel),
    .strobe(strobe)
  );

  irqRegs #(.PINS(PINS)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .hitVec   (hitVec),
    .intStatus(intStatus),
    .intMask  (intMask),
    .bankIrq  (bankIrq)
  );
endmodule

// File: rtl/gpioIrqChecker.sv
module gpioIrqChecker #(
  parameter int PINS = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            msTick,
  input logic            wrEn,
  input logic [1:0]      wrSel,
  input logic [PINS-1:0] wrData,
  input logic [PINS-1:0] hitVec,
  input logic [PINS-1:0] dbEnVec,
  input logic [PINS-1:0] intStatus,
  input logic [PINS-1:0] intMask
);
  // R5
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd0) |=> ((intStatus & $past(wrData) & ~$past(hitVec)) == '0));

  // R6
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (($past(hitVec) & ~intStatus) == '0));

  // R7
  mask_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrSel == 2'd2) |=> (($past(intMask) & ~intMask) == '0));

  // R9
  tick_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((hitVec & dbEnVec) != '0) |-> msTick);
endmodule

bind gpioEdgeIrq gpioIrqChecker #(.PINS(PINS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .msTick   (msTick),
  .wrEn     (wrEn),
  .wrSel    (wrSel),
  .wrData   (wrData),
  .hitVec   (hitVec),
  .dbEnVec  (dbEnVec),
  .intStatus(intStatus),
  .intMask  (intMask)
);

// File: tb/test_gpioEdgeIrq.sv
module test_gpioEdgeIrq;
  localparam int CLK_P = 10;
  localparam int PINS  = 8;
  localparam int CW    = 6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [PINS-1:0]   padLevel = '0;
  logic              msTick = 1'b0;
  logic [PINS*CW-1:0] pinCfg = '0;
  logic              wrEn = 1'b0;
  logic [1:0]        wrSel = 2'd3;
  logic [PINS-1:0]   wrData = '0;
  logic [PINS-1:0]   intStatus, intMask;
  logic              bankIrq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  gpioEdgeIrq #(.PINS(PINS)) i_gpioEdgeIrq (
    .clk(clk), .rstN(rstN), .padLevel(padLevel), .msTick(msTick),
    .pinCfg(pinCfg), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .intStatus(intStatus), .intMask(intMask), .bankIrq(bankIrq)
  );

  function automatic logic [CW-1:0] mkCfg(int edgeT, int expV, int db);
    return {db[0], expV[2:0], edgeT[1:0]};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int sel, int data);
    wrEn = 1'b1; wrSel = sel[1:0]; wrData = data[PINS-1:0];
    step();
    wrEn = 1'b0; wrSel = 2'd3; wrData = '0;
  endtask

  task automatic setAll(logic [CW-1:0] c);
    for (int i = 0; i < PINS; i++) pinCfg[i*CW +: CW] = c;
  endtask

  task automatic tick();
    msTick = 1'b1; step();
    msTick = 1'b0; step();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    #1;
    step(); step();
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 status", intStatus, 0);
    chk("R1 mask", intMask, 8'hFF);
    chk("R1 irq", bankIrq, 0);

    // R2 R3 R4 R10: sweep all edge selects, debounce off, one-cycle latch
    for (int t = 0; t < 4; t++) begin
      setAll(mkCfg(t, 0, 0));
      wr(0, 8'hFF);
      padLevel = 8'hA5;
      step();
      chk("R2/R4/R10 rise", intStatus, (t & 1) ? 8'hA5 : 0);
      wr(0, 8'hFF);
      chk("R5 full clear", intStatus, 0);
      padLevel = 8'h00;
      step();
      chk("R3/R4/R10 fall", intStatus, (t & 2) ? 8'hA5 : 0);
    end
    wr(0, 8'hFF);
    chk("R8 masked no irq", bankIrq, 0);

    // R7 mask clear and set
    setAll(mkCfg(3, 0, 0));
    wr(2, 8'h0F);
    chk("R7 unmask", intMask, 8'hF0);
    wr(1, 8'h01);
    chk("R7 mask set", intMask, 8'hF1);

    // R8 masked pin latches without irq
    padLevel[4] = 1'b1;
    step();
    chk("R8 masked latch", intStatus, 8'h10);
    chk("R8 masked irq", bankIrq, 0);
    padLevel[1] = 1'b1;
    step();
    chk("R8 unmasked status", intStatus, 8'h12);
    chk("R8 unmasked irq", bankIrq, 1);

    // R5 partial clear
    wr(0, 8'h02);
    chk("R5 partial", intStatus, 8'h10);
    chk("R8 irq drop", bankIrq, 0);

    // R6 collision: clear bits 2 and 4 while pad 2 toggles
    padLevel[2] = 1'b1;
    wr(0, 8'h14);
    chk("R6 edge wins", intStatus, 8'h04);
    chk("R6 irq", bankIrq, 1);

    // R11 re-latch after clear
    wr(0, 8'h04);
    chk("R11 cleared", intStatus, 0);
    padLevel[2] = 1'b0;
    step();
    chk("R11 relatch", intStatus, 8'h04);
    wr(0, 8'hFF);

    // R9 debounce sweep over every exponent on pin 0
    setAll(mkCfg(0, 0, 0));
    for (int e = 0; e < 8; e++) begin
      padLevel[0] = 1'b0;
      pinCfg[0 +: CW] = mkCfg(0, 0, 0);
      step();
      pinCfg[0 +: CW] = mkCfg(1, e, 1);
      wr(0, 8'hFF);
      padLevel[0] = 1'b1;
      for (int k = 0; k < (1 << e) - 1; k++) tick();
      padLevel[0] = 1'b0;
      step();
      tick();
      chk("R9 glitch", intStatus, 0);
      padLevel[0] = 1'b1;
      for (int k = 0; k < (1 << e) - 1; k++) tick();
      chk("R9 early", intStatus, 0);
      msTick = 1'b1; step();
      msTick = 1'b0;
      chk("R9 accept", intStatus, 8'h01);
      step();
    end
    finishRun();
  end
endmodule